// File: doc/BRIEF.md
# I2C Clock Period Generator

This block produces the clock line waveform of an I2C controller. It holds four programmable count values: a high count and a low count for standard rate, and a second pair for fast rate. The control word chooses which pair drives the waveform. When the sequencer raises its bus request, the block first holds the clock line released for the start condition hold time. It then alternates low and high phases until the request drops at the end of a high phase. After that the line is released and the block sits idle.

The block drives the line only through an active-low control (`scl_drive_low`), which is meant for an open-drain pad. It gives the sequencer a one-cycle strobe at the first cycle of every low phase and of every high phase, so that data changes can be placed against the clock. Counts can only be programmed while the block is disabled. Every count below a floor of six is raised to six.

Top module: `scl_period_gen`

## Requirements
- R1: While `rst` is high, and in every cycle after an edge at which `mode_ctl[0]` (run enable) was 0, `scl_drive_low`, `low_phase_stb` and `high_phase_stb` are all 0.
- R2: A write with `cfg_we`=1 at an edge where `mode_ctl[0]`=0 loads `cfg_data` into the count selected by `cfg_idx`: 0 standard high, 1 standard low, 2 fast high, 3 fast low. A write made while `mode_ctl[0]`=1 is ignored. All counts reset to 0.
- R3: When enabled and idle, a request sampled at an edge starts a start-hold interval. The line stays released for H+3 cycles, and the first low cycle follows directly after it. H is the effective high count.
- R4: Each low phase drives the line low for exactly L+1 consecutive cycles, where L is the effective low count. `low_phase_stb` is 1 in the first of those cycles only.
- R5: Each high phase releases the line for exactly H+8 cycles. `high_phase_stb` is 1 in its first cycle only, and the two strobes are never 1 together.
- R6: `mode_ctl[2:1]`=2'b10 selects the fast pair. Any other value selects the standard pair (2'b01 is the nominal code). The selection is sampled when a start hold begins and when a low phase begins, and it is then held for that low phase and the high phase that follows. A change made mid-phase first applies at the next low phase.
- R7: A programmed count below 6 acts as 6.
- R8: Clearing `mode_ctl[0]` in any phase releases the line from the next cycle on and returns all counters to their initial state, so a later request again begins with a full start hold.
- R9: If `bus_req` is 0 at the last cycle of a high phase, the block goes idle with the line released and no strobes. If it is 1, a new low phase starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ctl | input | 3 | Bit 0 run enable, bits 2:1 rate select |
| bus_req | input | 1 | Sequencer request to clock the bus |
| cfg_we | input | 1 | Count write strobe |
| cfg_idx | input | 2 | Which count to write |
| cfg_data | input | CNT_W | Count value to write |
| scl_drive_low | output | 1 | 1 pulls the clock line low |
| low_phase_stb | output | 1 | First cycle of a low phase |
| high_phase_stb | output | 1 | First cycle of a high phase |

## Verification
The bench measures every start hold, low run and high run and compares each one against lengths worked out from the programmed counts. An off-by-one in any counter limit, or a missing fixed overhead, shows up as a wrong run length. The rate is switched in the middle of the first low phase. A design that applies the switch at once would shorten that phase, or the high phase after it, instead of waiting for the next low phase. A write made while enabled must leave the measured periods unchanged. A count of 3 must still give a low phase of 7 cycles. A disable during a low phase must release the line in the next cycle. The full start hold that follows shows whether stale counter state was left behind.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HOLD,
        PH_LOW,
        PH_HIGH
    } phase_e;

    localparam int NUM_CNT    = 4;
    localparam int IDX_W      = $clog2(NUM_CNT);

    localparam int SEL_STD_HI = 0;
    localparam int SEL_STD_LO = 1;
    localparam int SEL_FST_HI = 2;
    localparam int SEL_FST_LO = 3;

    localparam int LOW_EXTRA  = 1;
    localparam int HIGH_EXTRA = 8;
    localparam int HOLD_EXTRA = 3;

    localparam logic [1:0] RATE_FAST = 2'b10;

    function automatic logic rate_is_fast(input logic [1:0] field);
        return field == RATE_FAST;
    endfunction

endpackage

// File: rtl/scl_cnt_bank.sv
module scl_cnt_bank
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [CNT_W-1:0] data_i,
    output logic [CNT_W-1:0] regs_o [NUM_CNT]
);

    logic [CNT_W-1:0] regs_q [NUM_CNT];

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (we_i && !en_i && idx_i == IDX_W'(g)) begin
                regs_q[g] <= data_i;
            end
        end

        assign regs_o[g] = regs_q[g];

        // R2: counts are frozen while the generator runs
        p_locked_r2: assert property (@(posedge clk) disable iff (rst)
            en_i |=> $stable(regs_q[g]))
            else $error("count slot changed while enabled");
    end

endmodule

// File: rtl/scl_pair_pick.sv
module scl_pair_pick
    import scl_gen_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MIN_CNT = 6
) (
    input  logic             fast_i,
    input  logic [CNT_W-1:0] regs_i [NUM_CNT],
    output logic [CNT_W-1:0] hi_o,
    output logic [CNT_W-1:0] lo_o
);

    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_CNT);

    logic [CNT_W-1:0] raw [2];
    logic [CNT_W-1:0] eff [2];

    assign raw[0] = fast_i ? regs_i[SEL_FST_HI] : regs_i[SEL_STD_HI];
    assign raw[1] = fast_i ? regs_i[SEL_FST_LO] : regs_i[SEL_STD_LO];

    for (genvar g = 0; g < 2; g++) begin : g_floor
        assign eff[g] = (raw[g] < FLOOR) ? FLOOR : raw[g];
    end

    assign hi_o = eff[0];
    assign lo_o = eff[1];

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             bus_req_i,
    input  logic             fast_live_i,
    input  logic [CNT_W-1:0] hi_i,
    input  logic [CNT_W-1:0] lo_i,
    output logic             fast_q_o,
    output logic             scl_low_o,
    output logic             low_stb_o,
    output logic             high_stb_o
);

    localparam int TW = CNT_W + 1;

    phase_e        phase_q, phase_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic          fast_q;
    logic          latch_rate;

    logic [TW-1:0] hold_lim, low_lim, high_lim;

    assign hold_lim = TW'(hi_i) + TW'(HOLD_EXTRA - 1);
    assign low_lim  = TW'(lo_i) + TW'(LOW_EXTRA - 1);
    assign high_lim = TW'(hi_i) + TW'(HIGH_EXTRA - 1);

    always_comb begin
        phase_d    = phase_q;
        cnt_d      = cnt_q + TW'(1);
        latch_rate = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                cnt_d = '0;
                if (bus_req_i) begin
                    phase_d    = PH_HOLD;
                    latch_rate = 1'b1;
                end
            end
            PH_HOLD: begin
                if (cnt_q == hold_lim) begin
                    phase_d    = PH_LOW;
                    cnt_d      = '0;
                    latch_rate = 1'b1;
                end
            end
            PH_LOW: begin
                if (cnt_q == low_lim) begin
                    phase_d = PH_HIGH;
                    cnt_d   = '0;
                end
            end
            PH_HIGH: begin
                if (cnt_q == high_lim) begin
                    cnt_d = '0;
                    if (bus_req_i) begin
                        phase_d    = PH_LOW;
                        latch_rate = 1'b1;
                    end else begin
                        phase_d = PH_IDLE;
                    end
                end
            end
            default: begin
                phase_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            fast_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            if (latch_rate) begin
                fast_q <= fast_live_i;
            end
        end
    end

    assign fast_q_o   = fast_q;
    assign scl_low_o  = (phase_q == PH_LOW);
    assign low_stb_o  = (phase_q == PH_LOW)  && (cnt_q == '0);
    assign high_stb_o = (phase_q == PH_HIGH) && (cnt_q == '0);

    p_release_r1: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (phase_q == PH_IDLE && !scl_low_o))
        else $error("line not released after disable");

    p_hold_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && en_i && bus_req_i) |=> (phase_q == PH_HOLD && cnt_q == '0))
        else $error("request did not open a start hold");

    p_low_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_low_o) |-> low_stb_o)
        else $error("low phase began without its strobe");

    p_low_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LOW) |-> (cnt_q <= low_lim))
        else $error("low counter ran past its limit");

    p_high_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HIGH) |-> (cnt_q <= high_lim))
        else $error("high counter ran past its limit");

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(low_stb_o && high_stb_o))
        else $error("both phase strobes active");

    p_rate_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HIGH || (phase_q == PH_LOW && cnt_q != '0)) |-> $stable(fast_q))
        else $error("rate selection changed inside a period");

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
    import scl_gen_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MIN_CNT = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode_ctl,
    input  logic             bus_req,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [CNT_W-1:0] cfg_data,
    output logic             scl_drive_low,
    output logic             low_phase_stb,
    output logic             high_phase_stb
);

    logic             run_en;
    logic             fast_live;
    logic             fast_held;
    logic [CNT_W-1:0] slots [NUM_CNT];
    logic [CNT_W-1:0] eff_hi, eff_lo;

    assign run_en    = mode_ctl[0];
    assign fast_live = rate_is_fast(mode_ctl[2:1]);

    scl_cnt_bank #(.CNT_W(CNT_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .en_i   (run_en),
        .we_i   (cfg_we),
        .idx_i  (cfg_idx),
        .data_i (cfg_data),
        .regs_o (slots)
    );

    scl_pair_pick #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) u_pick (
        .fast_i (fast_held),
        .regs_i (slots),
        .hi_o   (eff_hi),
        .lo_o   (eff_lo)
    );

    scl_phase_seq #(.CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .en_i        (run_en),
        .bus_req_i   (bus_req),
        .fast_live_i (fast_live),
        .hi_i        (eff_hi),
        .lo_i        (eff_lo),
        .fast_q_o    (fast_held),
        .scl_low_o   (scl_drive_low),
        .low_stb_o   (low_phase_stb),
        .high_stb_o  (high_phase_stb)
    );

endmodule

// File: tb/tb_scl_period_gen.sv
`timescale 1ns/1ps
module tb_scl_period_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_ctl = 3'b010;
    logic        bus_req = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = 2'd0;
    logic [15:0] cfg_data = 16'd0;
    logic        scl_drive_low, low_phase_stb, high_phase_stb;

    always #5 clk = ~clk;

    scl_period_gen dut (
        .clk(clk), .rst(rst), .mode_ctl(mode_ctl), .bus_req(bus_req),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .scl_drive_low(scl_drive_low), .low_phase_stb(low_phase_stb),
        .high_phase_stb(high_phase_stb)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // scoreboard: kind 0 start hold, 1 low run, 2 high run
    int    q_kind[$];
    int    q_len[$];
    string q_tag[$];
    int    arm_seq = 0;
    bit    mon_en = 1'b1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v < 6) ? 6 : v;
    endfunction

    task automatic push(input int kind, input int len, input string tag);
        q_kind.push_back(kind);
        q_len.push_back(len);
        q_tag.push_back(tag);
    endtask

    task automatic sb_compare(input int kind, input int len);
        if (q_kind.size() == 0) begin
            chk(0, "scoreboard-empty", len, -1);
        end else begin
            int    k = q_kind.pop_front();
            int    l = q_len.pop_front();
            string t = q_tag.pop_front();
            chk(k == kind, t, kind, k);
            chk(len == l, t, len, l);
        end
    endtask

    // monitor, sampling 2 ns after the rising edge
    int  seen_seq = 0;
    bit  waiting = 0, in_low = 0, in_high = 0;
    int  run_len = 0;
    always @(posedge clk) begin
        #2;
        if (mon_en) begin
            if (arm_seq != seen_seq) begin
                seen_seq = arm_seq;
                waiting  = 1;
                in_low   = 0;
                in_high  = 0;
                run_len  = 0;
            end
            if (waiting) begin
                if (scl_drive_low) begin
                    sb_compare(0, run_len);
                    waiting = 0; in_low = 1; run_len = 1;
                    chk(low_phase_stb, "R4 low strobe at start", int'(low_phase_stb), 1);
                end else begin
                    run_len++;
                end
            end else if (in_low) begin
                if (scl_drive_low) begin
                    run_len++;
                    chk(!low_phase_stb && !high_phase_stb, "R4 strobe inside low",
                        int'(low_phase_stb), 0);
                end else begin
                    sb_compare(1, run_len);
                    in_low = 0; in_high = 1; run_len = 1;
                    chk(high_phase_stb && !low_phase_stb, "R5 high strobe at start",
                        int'(high_phase_stb), 1);
                end
            end else if (in_high) begin
                if (!scl_drive_low) begin
                    run_len++;
                    chk(!low_phase_stb && !high_phase_stb, "R5 strobe inside high",
                        int'(high_phase_stb), 0);
                end else begin
                    sb_compare(2, run_len);
                    in_high = 0; in_low = 1; run_len = 1;
                    chk(low_phase_stb, "R4 low strobe at start", int'(low_phase_stb), 1);
                end
            end
        end
    end

    task automatic cfg_write(input int idx, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_data = 16'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_low_stb();
        do @(negedge clk); while (!low_phase_stb);
    endtask

    task automatic wait_high_stb();
        do @(negedge clk); while (!high_phase_stb);
    endtask

    // period 0 uses (h0,l0), later periods (h1,l1); values are raw counts
    task automatic run_burst(input int n, input int h0, input int l0, input int h1,
                             input int l1, input bit sw, input logic [1:0] spd2,
                             input string tag);
        push(0, eff(h0) + 3, {tag, " R3 hold"});
        for (int i = 0; i < n; i++) begin
            int hh = (i == 0) ? eff(h0) : eff(h1);
            int ll = (i == 0) ? eff(l0) : eff(l1);
            push(1, ll + 1, {tag, " R4 low"});
            if (i < n - 1) push(2, hh + 8, {tag, " R5 high"});
        end
        @(negedge clk);
        bus_req = 1'b1;
        arm_seq++;
        for (int i = 0; i < n; i++) begin
            wait_low_stb();
            if (i == 0 && sw) mode_ctl[2:1] = spd2;
            wait_high_stb();
        end
        bus_req = 1'b0;
        repeat (eff(h1) + 12) @(negedge clk);
        chk(q_kind.size() == 0, {tag, " R9 all periods seen"}, q_kind.size(), 0);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(!scl_drive_low && !low_phase_stb && !high_phase_stb,
                {tag, " R9 idle released"}, int'(scl_drive_low), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!scl_drive_low && !low_phase_stb && !high_phase_stb, "R1 during reset",
            int'(scl_drive_low), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!scl_drive_low && !low_phase_stb && !high_phase_stb, "R1 disabled",
            int'(scl_drive_low), 0);

        // reset counts are zero, so both floor to 6 (R7)
        mode_ctl = 3'b011;
        run_burst(2, 0, 0, 0, 0, 0, 2'b01, "R7 reset counts");

        // program all four counts while disabled (R2)
        mode_ctl[0] = 1'b0;
        cfg_write(0, 10);
        cfg_write(1, 20);
        cfg_write(2, 7);
        cfg_write(3, 3);
        mode_ctl = 3'b011;
        run_burst(3, 10, 20, 10, 20, 0, 2'b01, "R2 standard");

        // fast pair, low count 3 floors to 6 (R6, R7)
        mode_ctl = 3'b101;
        run_burst(2, 7, 3, 7, 3, 0, 2'b10, "R6 R7 fast");

        // rate switch inside the first low phase (R6)
        mode_ctl = 3'b011;
        run_burst(3, 10, 20, 7, 3, 1, 2'b10, "R6 midphase switch");

        // write while enabled must be ignored (R2)
        mode_ctl = 3'b011;
        cfg_write(0, 50);
        cfg_write(1, 40);
        run_burst(2, 10, 20, 10, 20, 0, 2'b01, "R2 locked write");

        // disable during a low phase (R8)
        mon_en = 1'b0;
        @(negedge clk);
        bus_req = 1'b1;
        wait_low_stb();
        repeat (2) @(negedge clk);
        mode_ctl[0] = 1'b0;
        @(negedge clk);
        chk(!scl_drive_low, "R8 release next cycle", int'(scl_drive_low), 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!scl_drive_low && !low_phase_stb && !high_phase_stb,
                "R8 R1 stays released", int'(scl_drive_low), 0);
        end
        bus_req = 1'b0;
        mode_ctl = 3'b011;
        q_kind.delete(); q_len.delete(); q_tag.delete();
        mon_en = 1'b1;
        run_burst(1, 10, 20, 10, 20, 0, 2'b01, "R8 restart");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule